// File: doc/BRIEF.md
# Bus Cycle Retry and Halt Controller

This block sequences the bus transfers of an asynchronous, strobe-based 16-bit bus master. A core hands it one transfer at a time. Each transfer carries an address-space code, a word address, two byte enables, a direction, write data and a read-modify-write flag. The block steps the transfer through four phases: address setup, strobe, wait and end. It drives the address strobe, the two byte data strobes, the direction line and the address and data buses. It reports a clean finish or a fault to the core, each as a one-clock pulse.

Three active-low inputs from the bus side decide how a cycle ends: transfer acknowledge, bus fault and hold-off. Each passes through a two-flop synchronizer before it is used. A fault alone ends the cycle with a fault report. A fault together with hold-off does not reach the core. The block ends the cycle, floats the address and data buses and waits for hold-off to be released. It then reruns the same transfer with the same space code, address and write data, and counts the retry. A read-modify-write transfer keeps the address strobe low from its read part through its write part. Such a transfer is never retried. Hold-off alone lets the running cycle finish and then blocks new transfers until it is released.

Top module: `busRetryCtl`

## Requirements
- R1: After reset the strobes are negated (high), the direction line reads 1 (read), both bus enables are 0, `reqReady` is 1 and `retryCount` is 0. A request accepted while `reqValid` and `reqReady` are both 1 enters the address phase at the next clock. In the address phase the address is driven and the address strobe stays negated.
- R2: A read asserts the address strobe and the selected data strobes one clock after the address phase. It holds them until the acknowledge is seen. It then pulses `doneOk` for exactly one clock with every strobe negated and `rdData` equal to the bus data captured at that edge.
- R3: A write drives `dirRead` to 0 from the address phase onward. It drives `dataOut` with `dataOe` = 1 from the strobe phase onward. Its data strobes come one clock later than the address strobe.
- R4: The cycle waits in the wait phase for as long as no acknowledge or fault is seen. A bus-side input that is asserted on a clock edge takes effect on the third clock edge after it.
- R5: A fault seen without hold-off ends the cycle with a one-clock `doneFault` pulse and no `doneOk`.
- R6: A fault seen together with hold-off, on a transfer that is not read-modify-write, reports nothing to the core. From the end phase onward it negates all strobes and drops `addrOe` and `dataOe` to 0, for as long as hold-off stays asserted.
- R7: Once hold-off is released, the same transfer restarts at the address phase with the same space code, address and write data. `retryCount` goes up by 1 at each retry termination.
- R8: If the fault input is still asserted at the moment the released hold-off is seen, `protoViol` pulses for one clock. It stays 0 when the fault was released earlier.
- R9: A read-modify-write transfer keeps the address strobe asserted from the strobe phase of its read part to the end of its write part. Between the two parts it waits for the acknowledge to be negated. A fault in it always gives `doneFault` and never floats the bus, even with hold-off asserted.
- R10: Hold-off alone lets the running cycle finish normally. While hold-off is seen, `reqReady` is 0 and no transfer starts. `reqReady` returns on the second clock edge after the release.
- R11: `retryCount` returns to 0 after a normal finish and at the start of each new transfer. It saturates at its maximum value.
- R12: `upperStrobeN` and `lowerStrobeN` are asserted only for byte enables set to 1, and only while the address strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core presents a transfer |
| reqReady | output | 1 | Transfer can be accepted this clock |
| reqSpace | input | FC_W | Address-space code of the transfer |
| reqAddr | input | ADDR_W | Word address |
| reqUpper | input | 1 | Upper byte enable |
| reqLower | input | 1 | Lower byte enable |
| reqRead | input | 1 | 1 = read, 0 = write (ignored when reqRmw is 1) |
| reqRmw | input | 1 | Read-modify-write transfer |
| reqWdata | input | DATA_W | Write data |
| doneOk | output | 1 | One-clock pulse: transfer finished normally |
| doneFault | output | 1 | One-clock pulse: transfer ended with a fault |
| rdData | output | DATA_W | Data captured by the last read |
| retryCount | output | RETRY_W | Retries of the current transfer |
| protoViol | output | 1 | Fault still asserted when hold-off released |
| addrStrobeN | output | 1 | Address strobe, active low |
| upperStrobeN | output | 1 | Upper data strobe, active low |
| lowerStrobeN | output | 1 | Lower data strobe, active low |
| dirRead | output | 1 | Direction, 1 = read |
| spaceCode | output | FC_W | Address-space code on the bus |
| addrOut | output | ADDR_W | Address bus value |
| addrOe | output | 1 | Address, space code and strobes are driven |
| dataOut | output | DATA_W | Write data bus value |
| dataOe | output | 1 | Data bus is driven |
| dataIn | input | DATA_W | Read data bus value |
| xferAckN | input | 1 | Transfer acknowledge, active low, asynchronous |
| busFaultN | input | 1 | Bus fault, active low, asynchronous |
| holdOffN | input | 1 | Hold-off, active low, asynchronous |

## Verification
The bench builds the block with `RETRY_W` = 2, so the retry counter reaches its saturation value of 3 after three retries of one transfer. A fourth retry then shows that it stays there. The other parameters keep their defaults. The two-stage synchronizer gives a fixed three-edge latency, and the bench checks that latency exactly in the wait, float and resume paths.

// File: rtl/busRetryPkg.sv
package busRetryPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_WAIT,
    ST_END,
    ST_TURN,
    ST_HOLD
  } busState_e;

  typedef enum logic [1:0] {
    TK_OK,
    TK_FAULT,
    TK_RETRY
  } termKind_e;

  typedef struct packed {
    logic latchReq;
    logic captureRd;
    logic asOn;
    logic dsOn;
    logic writeDir;
    logic addrDrive;
    logic dataDrive;
  } ctlStrobe_t;

endpackage

// File: rtl/busSync.sv
module busSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Active-low inputs: reset value is all ones (negated)
  generate
    if (STAGES == 1) begin : gSingle
      logic [WIDTH-1:0] stage0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage0 <= '1;
        else       stage0 <= din;
      end
      assign dout = stage0;
    end else begin : gChain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busCtl.sv
module busCtl
  import busRetryPkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               ackSeen,
  input  logic               faultSeen,
  input  logic               holdSeen,
  input  logic               curRead,
  input  logic               curRmw,
  output ctlStrobe_t         strobes,
  output logic               reqReady,
  output logic               doneOk,
  output logic               doneFault,
  output logic               protoViol,
  output logic [RETRY_W-1:0] retryCount
);
  localparam logic [RETRY_W-1:0] RETRY_MAX = '1;

  busState_e state, nextState;
  termKind_e kind, nextKind;
  logic phase;
  logic setPhase, bumpRetry, latchReq, captureRd;
  logic writeNow, floatNow;

  // RMW: read part first, write part after the turn
  assign writeNow = curRmw ? phase : !curRead;

  always_comb begin
    nextState = state;
    nextKind  = kind;
    latchReq  = 1'b0;
    captureRd = 1'b0;
    bumpRetry = 1'b0;
    setPhase  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid && !holdSeen) begin
          nextState = ST_ADDR;
          latchReq  = 1'b1;
        end
      end
      ST_ADDR: nextState = ST_STRB;
      ST_STRB: nextState = ST_WAIT;
      ST_WAIT: begin
        if (faultSeen) begin
          nextState = ST_END;
          if (holdSeen && !curRmw) begin
            nextKind  = TK_RETRY;
            bumpRetry = 1'b1;
          end else begin
            nextKind = TK_FAULT;
          end
        end else if (ackSeen) begin
          captureRd = !writeNow;
          if (curRmw && !phase) begin
            nextState = ST_TURN;
            setPhase  = 1'b1;
          end else begin
            nextState = ST_END;
            nextKind  = TK_OK;
          end
        end
      end
      ST_END:  nextState = (kind == TK_RETRY) ? ST_HOLD : ST_IDLE;
      ST_TURN: if (!ackSeen) nextState = ST_WAIT;
      ST_HOLD: if (!holdSeen) nextState = ST_ADDR;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= TK_OK;
      phase <= 1'b0;
    end else begin
      state <= nextState;
      kind  <= nextKind;
      if (latchReq)      phase <= 1'b0;
      else if (setPhase) phase <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCount <= '0;
    end else if (latchReq || (state == ST_END && kind == TK_OK)) begin
      retryCount <= '0;
    end else if (bumpRetry && retryCount != RETRY_MAX) begin
      retryCount <= retryCount + 1'b1;
    end
  end

  assign floatNow = (state == ST_IDLE) || (state == ST_HOLD) ||
                    (state == ST_END && kind == TK_RETRY);

  always_comb begin
    strobes.latchReq  = latchReq;
    strobes.captureRd = captureRd;
    strobes.asOn      = (state == ST_STRB) || (state == ST_WAIT) || (state == ST_TURN);
    strobes.dsOn      = (state == ST_WAIT) || (state == ST_STRB && !writeNow);
    strobes.writeDir  = writeNow && !floatNow;
    strobes.addrDrive = !floatNow;
    strobes.dataDrive = writeNow && !floatNow && (state != ST_ADDR);
  end

  assign reqReady  = (state == ST_IDLE) && !holdSeen;
  assign doneOk    = (state == ST_END) && (kind == TK_OK);
  assign doneFault = (state == ST_END) && (kind == TK_FAULT);
  assign protoViol = (state == ST_HOLD) && !holdSeen && faultSeen;
endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import busRetryPkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [FC_W-1:0]   reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqUpper,
  input  logic              reqLower,
  input  logic              reqRead,
  input  logic              reqRmw,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dataIn,
  output logic              curRead,
  output logic              curRmw,
  output logic [DATA_W-1:0] rdData,
  output logic              addrStrobeN,
  output logic              upperStrobeN,
  output logic              lowerStrobeN,
  output logic              dirRead,
  output logic [FC_W-1:0]   spaceCode,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [FC_W-1:0]   curSpace;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic              curUpper, curLower;

  // Request held for the whole transfer, retries included
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSpace <= '0;
      curAddr  <= '0;
      curWdata <= '0;
      curUpper <= 1'b0;
      curLower <= 1'b0;
      curRead  <= 1'b1;
      curRmw   <= 1'b0;
    end else if (strobes.latchReq) begin
      curSpace <= reqSpace;
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curUpper <= reqUpper;
      curLower <= reqLower;
      curRead  <= reqRead;
      curRmw   <= reqRmw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rdData <= '0;
    else if (strobes.captureRd) rdData <= dataIn;
  end

  assign addrStrobeN  = !strobes.asOn;
  assign upperStrobeN = !(strobes.dsOn && curUpper);
  assign lowerStrobeN = !(strobes.dsOn && curLower);
  assign dirRead      = !strobes.writeDir;
  assign spaceCode    = curSpace;
  assign addrOut      = curAddr;
  assign addrOe       = strobes.addrDrive;
  assign dataOut      = curWdata;
  assign dataOe       = strobes.dataDrive;
endmodule

// File: rtl/busRetryCtl.sv
module busRetryCtl
  import busRetryPkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int FC_W        = 3,
  parameter int RETRY_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [FC_W-1:0]    reqSpace,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqUpper,
  input  logic               reqLower,
  input  logic               reqRead,
  input  logic               reqRmw,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               doneOk,
  output logic               doneFault,
  output logic [DATA_W-1:0]  rdData,
  output logic [RETRY_W-1:0] retryCount,
  output logic               protoViol,
  output logic               addrStrobeN,
  output logic               upperStrobeN,
  output logic               lowerStrobeN,
  output logic               dirRead,
  output logic [FC_W-1:0]    spaceCode,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               addrOe,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               xferAckN,
  input  logic               busFaultN,
  input  logic               holdOffN
);
  localparam int N_SENSE = 3;

  logic [N_SENSE-1:0] senseSync;
  ctlStrobe_t         strobes;
  logic               curRead, curRmw;

  busSync #(.WIDTH(N_SENSE), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({xferAckN, busFaultN, holdOffN}),
    .dout(senseSync)
  );

  busCtl #(.RETRY_W(RETRY_W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .ackSeen   (!senseSync[2]),
    .faultSeen (!senseSync[1]),
    .holdSeen  (!senseSync[0]),
    .curRead   (curRead),
    .curRmw    (curRmw),
    .strobes   (strobes),
    .reqReady  (reqReady),
    .doneOk    (doneOk),
    .doneFault (doneFault),
    .protoViol (protoViol),
    .retryCount(retryCount)
  );

  busDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqSpace    (reqSpace),
    .reqAddr     (reqAddr),
    .reqUpper    (reqUpper),
    .reqLower    (reqLower),
    .reqRead     (reqRead),
    .reqRmw      (reqRmw),
    .reqWdata    (reqWdata),
    .dataIn      (dataIn),
    .curRead     (curRead),
    .curRmw      (curRmw),
    .rdData      (rdData),
    .addrStrobeN (addrStrobeN),
    .upperStrobeN(upperStrobeN),
    .lowerStrobeN(lowerStrobeN),
    .dirRead     (dirRead),
    .spaceCode   (spaceCode),
    .addrOut     (addrOut),
    .addrOe      (addrOe),
    .dataOut     (dataOut),
    .dataOe      (dataOe)
  );
endmodule

// File: rtl/busRetryChk.sv
module busRetryChk #(
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               doneOk,
  input logic               doneFault,
  input logic               protoViol,
  input logic [RETRY_W-1:0] retryCount,
  input logic               addrStrobeN,
  input logic               upperStrobeN,
  input logic               lowerStrobeN,
  input logic               addrOe,
  input logic               dataOe
);
  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (addrOe && addrStrobeN));

  p_ok_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |=> !doneOk);

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneFault |=> !doneFault);

  p_single_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneFault));

  p_float_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !addrOe |-> (addrStrobeN && upperStrobeN && lowerStrobeN && !dataOe));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(retryCount) |->
      (retryCount == '0 || retryCount == $past(retryCount) + 1'b1));

  p_viol_floated_r8: assert property (@(posedge clk) disable iff (!rstN)
    protoViol |-> !addrOe);

  p_clear_on_ok_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |=> (retryCount == '0));

  p_ds_within_as_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!upperStrobeN || !lowerStrobeN) |-> !addrStrobeN);
endmodule

bind busRetryCtl busRetryChk #(.RETRY_W(RETRY_W)) uChk (.*);

// File: tb/tb_busRetryCtl.sv
module tb_busRetryCtl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [2:0]  reqSpace = '0;
  logic [22:0] reqAddr = '0;
  logic        reqUpper = 1'b0, reqLower = 1'b0, reqRead = 1'b1, reqRmw = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        doneOk, doneFault, protoViol;
  logic [15:0] rdData;
  logic [RW-1:0] retryCount;
  logic        addrStrobeN, upperStrobeN, lowerStrobeN, dirRead;
  logic [2:0]  spaceCode;
  logic [22:0] addrOut;
  logic        addrOe, dataOe;
  logic [15:0] dataOut;
  logic [15:0] dataIn = '0;
  logic        xferAckN = 1'b1, busFaultN = 1'b1, holdOffN = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busRetryCtl #(.RETRY_W(RW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSpace(reqSpace), .reqAddr(reqAddr), .reqUpper(reqUpper), .reqLower(reqLower),
    .reqRead(reqRead), .reqRmw(reqRmw), .reqWdata(reqWdata),
    .doneOk(doneOk), .doneFault(doneFault), .rdData(rdData), .retryCount(retryCount),
    .protoViol(protoViol), .addrStrobeN(addrStrobeN), .upperStrobeN(upperStrobeN),
    .lowerStrobeN(lowerStrobeN), .dirRead(dirRead), .spaceCode(spaceCode),
    .addrOut(addrOut), .addrOe(addrOe), .dataOut(dataOut), .dataOe(dataOe),
    .dataIn(dataIn), .xferAckN(xferAckN), .busFaultN(busFaultN), .holdOffN(holdOffN)
  );

  // {isRead, upper, lower, waits[2:0], addr[22:0], data[15:0]}
  localparam logic [44:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b1, 3'd0, 23'h012345, 16'hBEEF},
    {1'b0, 1'b1, 1'b1, 3'd0, 23'h000010, 16'h1357},
    {1'b1, 1'b1, 1'b0, 3'd2, 23'h7FFFFF, 16'hA500},
    {1'b0, 1'b0, 1'b1, 3'd3, 23'h2AAAAA, 16'h00C3},
    {1'b1, 1'b0, 1'b1, 3'd5, 23'h000000, 16'h0F0F},
    {1'b0, 1'b1, 1'b0, 3'd1, 23'h555555, 16'hFFFF}
  };

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive a request; returns at the negedge inside the address phase
  task automatic startReq(input logic rd, input logic u, input logic l, input logic rmw,
                          input logic [2:0] f, input logic [22:0] a, input logic [15:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqUpper = u; reqLower = l; reqRmw = rmw;
    reqSpace = f; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Assert acknowledge in the wait phase and check normal completion
  task automatic finishAck(input logic rd, input logic [15:0] expData, input string tag);
    int n = 0;
    xferAckN = 1'b0;
    do begin @(negedge clk); n++; end while (!(doneOk || doneFault) && n < 12);
    chkEq({tag, " R4 ack latency"}, n, 3);
    chkEq({tag, " R2 doneOk"}, doneOk, 1);
    chkEq({tag, " R2 strobe negated at end"}, addrStrobeN, 1);
    if (rd) chkEq({tag, " R2 read data"}, rdData, expData);
    xferAckN = 1'b1;
    @(negedge clk);
    chkEq({tag, " R2 done is a pulse"}, doneOk, 0);
    chkEq({tag, " R11 count cleared"}, retryCount, 0);
    @(negedge clk);
  endtask

  // From a wait-phase negedge: retry termination, hold, resume; returns in the rerun wait phase
  task automatic doRetry(input logic [22:0] a, input logic [2:0] f, input logic [15:0] wd,
                         input int expCount);
    int n = 0;
    logic viol = 1'b0;
    busFaultN = 1'b0; holdOffN = 1'b0;
    do begin @(negedge clk); n++; end while (addrOe && n < 12);
    chkEq("R6 float latency", n, 3);
    chkEq("R6 strobe negated", addrStrobeN, 1);
    chkEq("R6 data floated", dataOe, 0);
    chkEq("R6 no fault report", doneFault, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chkEq("R6 stays floated", addrOe, 0);
    end
    chkEq("R7 retry count step R11 saturation", retryCount, expCount);
    busFaultN = 1'b1;
    repeat (2) @(negedge clk);
    holdOffN = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; if (protoViol) viol = 1'b1; end while (!addrOe && n < 12);
    chkEq("R7 resume latency", n, 3);
    chkEq("R8 no violation when fault released first", viol, 0);
    chkEq("R7 same address", addrOut, a);
    chkEq("R7 same space code", spaceCode, f);
    @(negedge clk);
    chkEq("R7 same write data", dataOut, wd);
    chkEq("R7 data driven", dataOe, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 addr strobe", addrStrobeN, 1);
    chkEq("R1 data strobes", {upperStrobeN, lowerStrobeN}, 2'b11);
    chkEq("R1 direction", dirRead, 1);
    chkEq("R1 bus floated", {addrOe, dataOe}, 2'b00);
    chkEq("R1 ready", reqReady, 1);
    chkEq("R1 retry count", retryCount, 0);

    // Table of plain transfers: R1 R2 R3 R4 R12
    for (int v = 0; v < 6; v++) begin
      logic rd; logic u; logic l; logic [2:0] w; logic [22:0] a; logic [15:0] d;
      {rd, u, l, w, a, d} = VEC[v];
      dataIn = d;
      startReq(rd, u, l, 1'b0, a[2:0], a, d);
      chkEq("R1 address phase drives address", addrOut, a);
      chkEq("R1 address phase strobe negated", addrStrobeN, 1);
      chkEq("R1 space code", spaceCode, a[2:0]);
      chkEq("R3 direction", dirRead, rd);
      @(negedge clk);
      chkEq("R2 strobe asserted", addrStrobeN, 0);
      if (rd) begin
        chkEq("R12 read byte strobes", {upperStrobeN, lowerStrobeN}, {!u, !l});
      end else begin
        chkEq("R3 data strobes late", {upperStrobeN, lowerStrobeN}, 2'b11);
        chkEq("R3 data driven", {dataOe, dataOut}, {1'b1, d});
      end
      @(negedge clk);
      chkEq("R12 byte strobes in wait", {upperStrobeN, lowerStrobeN}, {!u, !l});
      for (int k = 0; k < int'(w); k++) begin
        @(negedge clk);
        chkEq("R4 waiting without ack", {doneOk, doneFault, addrStrobeN}, 3'b000);
      end
      finishAck(rd, d, "table");
    end

    // R5 fault alone
    startReq(1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 23'h001234, 16'h4321);
    repeat (2) @(negedge clk);
    begin
      int n = 0;
      busFaultN = 1'b0;
      do begin @(negedge clk); n++; end while (!(doneOk || doneFault) && n < 12);
      chkEq("R5 fault latency", n, 3);
      chkEq("R5 fault reported", {doneFault, doneOk}, 2'b10);
      chkEq("R5 bus not floated", addrOe, 1);
      busFaultN = 1'b1;
      @(negedge clk);
      chkEq("R5 fault is a pulse", doneFault, 0);
      repeat (2) @(negedge clk);
    end

    // R6 R7 R11 retries with saturation
    startReq(1'b0, 1'b1, 1'b1, 1'b0, 3'd6, 23'h2A5A5A, 16'hC0DE);
    repeat (2) @(negedge clk);
    doRetry(23'h2A5A5A, 3'd6, 16'hC0DE, 1);
    doRetry(23'h2A5A5A, 3'd6, 16'hC0DE, 2);
    doRetry(23'h2A5A5A, 3'd6, 16'hC0DE, 3);
    doRetry(23'h2A5A5A, 3'd6, 16'hC0DE, 3);
    finishAck(1'b0, 16'h0, "after retries");

    // R8 fault still asserted when hold-off released
    dataIn = 16'h7E57;
    startReq(1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 23'h0ABCDE, 16'h0);
    repeat (2) @(negedge clk);
    begin
      int n = 0;
      logic viol = 1'b0;
      busFaultN = 1'b0; holdOffN = 1'b0;
      do begin @(negedge clk); n++; end while (addrOe && n < 12);
      repeat (3) @(negedge clk);
      holdOffN = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; if (protoViol) viol = 1'b1; end while (!addrOe && n < 12);
      chkEq("R8 violation flagged", viol, 1);
      chkEq("R7 retried address", addrOut, 23'h0ABCDE);
      busFaultN = 1'b1;
      repeat (2) @(negedge clk);
      finishAck(1'b1, 16'h7E57, "after violation");
    end

    // R9 read-modify-write with continuous address strobe
    dataIn = 16'h1234;
    startReq(1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 23'h000ABC, 16'h5A5A);
    @(negedge clk);
    chkEq("R9 read part direction", dirRead, 1);
    @(negedge clk);
    begin
      int n = 0;
      logic dropped = 1'b0;
      xferAckN = 1'b0;
      do begin @(negedge clk); n++; if (addrStrobeN) dropped = 1'b1; end
        while (dirRead && n < 12);
      chkEq("R9 turn latency", n, 3);
      xferAckN = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; if (addrStrobeN) dropped = 1'b1; end
        while (upperStrobeN && n < 12);
      chkEq("R9 write part after ack negated", n, 3);
      chkEq("R9 address strobe held", dropped, 0);
      chkEq("R9 write data", {dataOe, dataOut}, {1'b1, 16'h5A5A});
      finishAck(1'b1, 16'h1234, "rmw");
    end

    // R9 fault with hold-off in read-modify-write is never retried
    startReq(1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 23'h000ABE, 16'h0);
    repeat (2) @(negedge clk);
    begin
      int n = 0;
      busFaultN = 1'b0; holdOffN = 1'b0;
      do begin @(negedge clk); n++; end while (!(doneOk || doneFault) && addrOe && n < 12);
      chkEq("R9 rmw fault reported", doneFault, 1);
      chkEq("R9 rmw not floated", addrOe, 1);
      busFaultN = 1'b1; holdOffN = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!reqReady && n < 12);
    end

    // R10 hold-off alone
    dataIn = 16'h9999;
    startReq(1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 23'h003333, 16'h0);
    repeat (2) @(negedge clk);
    begin
      int n = 0;
      xferAckN = 1'b0; holdOffN = 1'b0;
      do begin @(negedge clk); n++; end while (!(doneOk || doneFault) && n < 12);
      chkEq("R10 running cycle completes", doneOk, 1);
      xferAckN = 1'b1;
      reqValid = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chkEq("R10 no new transfer", {reqReady, addrOe}, 2'b00);
      end
      reqValid = 1'b0;
      holdOffN = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!reqReady && n < 12);
      chkEq("R10 ready after release", n, 2);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule